// File: doc/BRIEF.md
# Display RAM Address Counter with Mode Wrap

This block holds the pointer that a character display controller uses for every data access to its display RAM and its character RAM. A host-side decoder loads the pointer with either a display RAM address or a character RAM address. It then pulses a step strobe after each data read or write, and the pointer moves by one in the direction set by the entry direction input. For display RAM targets the step follows the wrap rules of the selected screen layout: one line of 32, two lines of 16, or one line of 9. A read or write that runs off the end of a line continues on the next line.

Separately, the block keeps a display shift offset that is moved left or right by a shift command. From this offset it derives, for all 32 visible positions, the RAM address that the position shows. Shifting wraps each line within itself. It does not roll into the neighbouring line. A small state machine records whether the last load aimed at display RAM or character RAM, so that downstream logic can suppress the cursor while the pointer addresses character RAM.

The state machine has two states. SEL_DISPLAY is the reset state and SEL_CHAR is the other. A display load takes either state to SEL_DISPLAY (transition GO_DISPLAY). A character load without a display load in the same cycle takes either state to SEL_CHAR (transition GO_CHAR). In any other cycle the state holds (transition STAY).

Top module: `ram_addr_counter`

## Requirements
- R1: After reset the pointer is 00h, the select flag is 0 (display RAM), and the shift offset is zero, so every visible position shows its unshifted address.
- R2: A display load sets all 7 pointer bits from load_addr_i and clears the select flag. A character load sets bits 5..0 from load_addr_i, keeps bit 6, and sets the flag. A load takes priority over a step in the same cycle, and a display load takes priority over a character load.
- R3: While the flag is 1, a step changes the pointer by exactly one, modulo 128, upward when inc_i is 1 and downward otherwise. A carry or borrow out of bit 5 therefore changes bit 6 (3Fh steps up to 40h, and 7Fh steps up to 00h).
- R4: In mode_i 0 (one line of 32), and also for code 3, a display step runs over 00h..4Fh. Upward, 4Fh goes to 00h. Downward, 00h goes to 4Fh. Every other address moves by one.
- R5: In mode_i 1 (two lines of 16), the lines are 00h..27h and 40h..67h. Upward, 27h goes to 40h and 67h goes to 00h. Downward, 40h goes to 27h and 00h goes to 67h.
- R6: In mode_i 2 (one line of 9), the space is 00h..27h. Upward, 27h goes to 00h. Downward, 00h goes to 27h.
- R7: A shift pulse with shift_right_i = 0 (left) raises the offset by one, and with shift_right_i = 1 (right) lowers it by one, modulo 80. Position p (0..31) is reported in vis_addr_o bits [7p+6:7p].
- R8: In mode 1, position p < 16 shows (p + offset mod 40) mod 40, and position p >= 16 shows 40h + ((p - 16 + offset mod 40) mod 40). So one right shift from zero makes position 0 show 27h and position 16 show 67h.
- R9: In mode 0 (and 3), position p shows (p + offset) mod 80, so one right shift from zero makes position 0 show 4Fh.
- R10: In mode 2, position p < 9 shows (p + offset mod 40) mod 40, and positions 9..31 read 00h.
- R11: A shift pulse leaves the pointer and the flag unchanged, and a step or load leaves the shift offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Screen layout: 0 one line of 32, 1 two lines of 16, 2 one line of 9, 3 as 0 |
| inc_i | input | 1 | Step direction: 1 up, 0 down |
| step_i | input | 1 | One-cycle strobe after each data access |
| load_disp_i | input | 1 | Load a display RAM address |
| load_char_i | input | 1 | Load a character RAM address |
| load_addr_i | input | 7 | Address for either load |
| shift_i | input | 1 | One-cycle display shift command |
| shift_right_i | input | 1 | Shift direction: 1 right, 0 left |
| addr_o | output | 7 | Current access address |
| char_sel_o | output | 1 | 1 when the last load targeted character RAM |
| vis_addr_o | output | 224 | RAM address for each of 32 visible positions, 7 bits each |

## Verification
The step function is tried at each layout's line ends in both directions. In the two-line layout, this separates a jump to the other line from a plain roll to zero. The same addresses are then stepped in character mode, where the carry into bit 6 must win over any display wrap. Shift patterns include a single right shift from zero, a net left shift, and a full 80-step circuit. These show whether each line wraps on its own 40-entry space in the line layouts and on the 80-entry space in the wide layout. Simultaneous load, step and shift pulses separate the priority rules from the independence of pointer and offset.

// File: rtl/rac_pkg.sv
package rac_pkg;

    // Screen layout selection; code 3 behaves like the wide layout.
    typedef enum logic [1:0] {
        SCR_WIDE     = 2'd0,
        SCR_DUAL     = 2'd1,
        SCR_NARROW   = 2'd2,
        SCR_WIDE_ALT = 2'd3
    } screen_mode_e;

    // Target of the most recent address load.
    typedef enum logic {
        SEL_DISPLAY = 1'b0,
        SEL_CHAR    = 1'b1
    } sel_state_e;

endpackage

// File: rtl/rac_sel_fsm.sv
module rac_sel_fsm
    import rac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_disp_i,
    input  logic load_char_i,
    output logic char_sel_o
);

    sel_state_e state_q;
    sel_state_e state_d;

    // Transitions: GO_DISPLAY, GO_CHAR, STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_DISPLAY: begin
                if (!load_disp_i && load_char_i) state_d = SEL_CHAR;
            end
            SEL_CHAR: begin
                if (load_disp_i) state_d = SEL_DISPLAY;
            end
            default: state_d = SEL_DISPLAY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_DISPLAY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEL_CHAR:    char_sel_o = 1'b1;
            SEL_DISPLAY: char_sel_o = 1'b0;
            default:     char_sel_o = 1'b0;
        endcase
    end

    // R2: a display load always lands in the display state
    assert_disp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_disp_i |=> !char_sel_o);

    // R2: a lone character load lands in the character state
    assert_char_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_char_i && !load_disp_i) |=> char_sel_o);

    // R2: without a load the flag is kept
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_char_i && !load_disp_i) |=> $stable(char_sel_o));

endmodule

// File: rtl/rac_counter.sv
module rac_counter
    import rac_pkg::*;
#(
    parameter int AW         = 7,
    parameter int SPACE      = 80,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  screen_mode_e  mode_i,
    input  logic          char_mode_i,
    input  logic          inc_i,
    input  logic          step_i,
    input  logic          load_disp_i,
    input  logic          load_char_i,
    input  logic [AW-1:0] load_addr_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] WIDE_TOP = AW'(SPACE - 1);
    localparam logic [AW-1:0] L1_END   = AW'(LINE_LEN - 1);
    localparam logic [AW-1:0] L2_BASE  = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_END   = AW'(LINE2_BASE + LINE_LEN - 1);
    localparam logic [AW-1:0] ZERO     = '0;
    localparam logic [AW-1:0] ONE      = AW'(1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] stepped;

    // Next address for one step under the active layout
    always_comb begin
        if (char_mode_i) begin
            stepped = inc_i ? addr_q + ONE : addr_q - ONE;
        end else begin
            unique case (mode_i)
                SCR_DUAL: begin
                    if (inc_i) begin
                        if (addr_q == L1_END)      stepped = L2_BASE;
                        else if (addr_q == L2_END) stepped = ZERO;
                        else                       stepped = addr_q + ONE;
                    end else begin
                        if (addr_q == L2_BASE)     stepped = L1_END;
                        else if (addr_q == ZERO)   stepped = L2_END;
                        else                       stepped = addr_q - ONE;
                    end
                end
                SCR_NARROW: begin
                    if (inc_i) stepped = (addr_q >= L1_END) ? ZERO : addr_q + ONE;
                    else       stepped = (addr_q == ZERO || addr_q > L1_END) ? L1_END : addr_q - ONE;
                end
                SCR_WIDE, SCR_WIDE_ALT: begin
                    if (inc_i) stepped = (addr_q >= WIDE_TOP) ? ZERO : addr_q + ONE;
                    else       stepped = (addr_q == ZERO || addr_q > WIDE_TOP) ? WIDE_TOP : addr_q - ONE;
                end
                default: stepped = addr_q;
            endcase
        end
    end

    always_comb begin
        addr_d = addr_q;
        if (load_disp_i)      addr_d = load_addr_i;
        else if (load_char_i) addr_d = {addr_q[AW-1], load_addr_i[AW-2:0]};
        else if (step_i)      addr_d = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    logic plain_step;
    logic is_wide;
    assign plain_step = step_i && !load_disp_i && !load_char_i;
    assign is_wide    = (mode_i == SCR_WIDE) || (mode_i == SCR_WIDE_ALT);

    // R3: character-mode step is an exact modulo-128 move
    assert_char_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && char_mode_i) |=>
        (addr_q == ($past(inc_i) ? $past(addr_q) + ONE : $past(addr_q) - ONE)));

    // R2: character load keeps the top bit and takes the low bits
    assert_char_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_char_i && !load_disp_i) |=>
        (addr_q[AW-1] == $past(addr_q[AW-1])) && (addr_q[AW-2:0] == $past(load_addr_i[AW-2:0])));

    // R4: wide layout stays inside its space
    assert_wide_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && !char_mode_i && is_wide && addr_q <= WIDE_TOP) |=> (addr_q <= WIDE_TOP));

    // R5: dual layout stays inside its two lines
    assert_dual_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && !char_mode_i && mode_i == SCR_DUAL &&
         (addr_q <= L1_END || (addr_q >= L2_BASE && addr_q <= L2_END))) |=>
        (addr_q <= L1_END || (addr_q >= L2_BASE && addr_q <= L2_END)));

    // R6: narrow layout stays inside its single line
    assert_narrow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && !char_mode_i && mode_i == SCR_NARROW && addr_q <= L1_END) |=> (addr_q <= L1_END));

endmodule

// File: rtl/rac_shift_map.sv
module rac_shift_map
    import rac_pkg::*;
#(
    parameter int AW         = 7,
    parameter int SPACE      = 80,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int POSITIONS  = 32,
    parameter int HALF       = 16,
    parameter int NARROW     = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  screen_mode_e            mode_i,
    input  logic                    shift_i,
    input  logic                    shift_right_i,
    output logic [POSITIONS*AW-1:0] vis_addr_o
);

    localparam int OW = $clog2(SPACE);
    localparam int SW = OW + 1;
    localparam logic [OW-1:0] OFF_TOP  = OW'(SPACE - 1);
    localparam logic [OW-1:0] OFF_ONE  = OW'(1);
    localparam logic [OW-1:0] OFF_LINE = OW'(LINE_LEN);

    logic [OW-1:0] off_q;
    logic [OW-1:0] off_d;
    logic [OW-1:0] off_line;

    always_comb begin
        off_d = off_q;
        if (shift_i) begin
            if (shift_right_i) off_d = (off_q == '0) ? OFF_TOP : off_q - OFF_ONE;
            else               off_d = (off_q >= OFF_TOP) ? '0 : off_q + OFF_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign off_line = (off_q >= OFF_LINE) ? off_q - OFF_LINE : off_q;

    for (genvar p = 0; p < POSITIONS; p++) begin : g_pos
        localparam int LQ = (p < HALF) ? p : p - HALF;
        localparam logic [AW-1:0] LBASE = (p < HALF) ? '0 : AW'(LINE2_BASE);
        localparam bit IN_NARROW = (p < NARROW);

        logic [SW-1:0] wide_sum;
        logic [SW-1:0] wide_wrap;
        logic [SW-1:0] dual_sum;
        logic [SW-1:0] dual_wrap;
        logic [SW-1:0] nar_sum;
        logic [SW-1:0] nar_wrap;
        logic [AW-1:0] pos_addr;

        always_comb begin
            wide_sum  = {1'b0, off_q} + SW'(p);
            wide_wrap = (wide_sum >= SW'(SPACE)) ? wide_sum - SW'(SPACE) : wide_sum;
            dual_sum  = {1'b0, off_line} + SW'(LQ);
            dual_wrap = (dual_sum >= SW'(LINE_LEN)) ? dual_sum - SW'(LINE_LEN) : dual_sum;
            nar_sum   = {1'b0, off_line} + SW'(p);
            nar_wrap  = (nar_sum >= SW'(LINE_LEN)) ? nar_sum - SW'(LINE_LEN) : nar_sum;
            unique case (mode_i)
                SCR_DUAL:   pos_addr = LBASE + AW'(dual_wrap);
                SCR_NARROW: pos_addr = IN_NARROW ? AW'(nar_wrap) : '0;
                SCR_WIDE, SCR_WIDE_ALT: pos_addr = AW'(wide_wrap);
                default:    pos_addr = '0;
            endcase
        end

        assign vis_addr_o[p*AW +: AW] = pos_addr;
    end

    // R7: offset stays inside its modulo range
    assert_offset_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OFF_TOP);

    // R7: left shift moves the offset up by one unless at the top
    assert_left_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !shift_right_i && off_q < OFF_TOP) |=> (off_q == $past(off_q) + OFF_ONE));

    // R11: without a shift the offset is kept
    assert_offset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(off_q));

endmodule

// File: rtl/ram_addr_counter.sv
module ram_addr_counter
    import rac_pkg::*;
#(
    parameter int AW         = 7,
    parameter int SPACE      = 80,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int POSITIONS  = 32,
    parameter int NARROW     = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic                    inc_i,
    input  logic                    step_i,
    input  logic                    load_disp_i,
    input  logic                    load_char_i,
    input  logic [AW-1:0]           load_addr_i,
    input  logic                    shift_i,
    input  logic                    shift_right_i,
    output logic [AW-1:0]           addr_o,
    output logic                    char_sel_o,
    output logic [POSITIONS*AW-1:0] vis_addr_o
);

    localparam int HALF = POSITIONS / 2;

    screen_mode_e mode;
    logic         char_sel;

    assign mode = screen_mode_e'(mode_i);

    rac_sel_fsm u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_disp_i (load_disp_i),
        .load_char_i (load_char_i),
        .char_sel_o  (char_sel)
    );

    rac_counter #(
        .AW         (AW),
        .SPACE      (SPACE),
        .LINE_LEN   (LINE_LEN),
        .LINE2_BASE (LINE2_BASE)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .char_mode_i (char_sel),
        .inc_i       (inc_i),
        .step_i      (step_i),
        .load_disp_i (load_disp_i),
        .load_char_i (load_char_i),
        .load_addr_i (load_addr_i),
        .addr_o      (addr_o)
    );

    rac_shift_map #(
        .AW         (AW),
        .SPACE      (SPACE),
        .LINE_LEN   (LINE_LEN),
        .LINE2_BASE (LINE2_BASE),
        .POSITIONS  (POSITIONS),
        .HALF       (HALF),
        .NARROW     (NARROW)
    ) u_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .shift_i       (shift_i),
        .shift_right_i (shift_right_i),
        .vis_addr_o    (vis_addr_o)
    );

    assign char_sel_o = char_sel;

    // R11: a shift alone leaves the access pointer in place
    assert_shift_keeps_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !step_i && !load_disp_i && !load_char_i) |=> $stable(addr_o));

endmodule

// File: tb/test_ram_addr_counter.sv
module test_ram_addr_counter;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic         inc_i = 1'b1;
    logic         step_i = 1'b0;
    logic         load_disp_i = 1'b0;
    logic         load_char_i = 1'b0;
    logic [6:0]   load_addr_i = '0;
    logic         shift_i = 1'b0;
    logic         shift_right_i = 1'b0;
    logic [6:0]   addr_o;
    logic         char_sel_o;
    logic [223:0] vis_addr_o;

    int checks = 0;
    int errors = 0;
    int exp_off = 0;

    always #4 clk = ~clk;

    ram_addr_counter i_ram_addr_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .inc_i         (inc_i),
        .step_i        (step_i),
        .load_disp_i   (load_disp_i),
        .load_char_i   (load_char_i),
        .load_addr_i   (load_addr_i),
        .shift_i       (shift_i),
        .shift_right_i (shift_right_i),
        .addr_o        (addr_o),
        .char_sel_o    (char_sel_o),
        .vis_addr_o    (vis_addr_o)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int exp_vis(input int mode, input int off, input int p);
        int o;
        o = off % 40;
        if (mode == 1) begin
            if (p < 16) return (p + o) % 40;
            return 64 + ((p - 16 + o) % 40);
        end
        if (mode == 2) return (p < 9) ? (p + o) % 40 : 0;
        return (p + off) % 80;
    endfunction

    function automatic int vis(input int p);
        return int'(vis_addr_o[p*7 +: 7]);
    endfunction

    // One-cycle stimulus: driven on a falling edge, sampled on the next one
    task automatic pulse(input logic ld, input logic lc, input logic [6:0] a,
                         input logic st, input logic inc, input logic sh, input logic shr);
        @(negedge clk);
        load_disp_i = ld; load_char_i = lc; load_addr_i = a;
        step_i = st; inc_i = inc; shift_i = sh; shift_right_i = shr;
        @(negedge clk);
        load_disp_i = 1'b0; load_char_i = 1'b0; step_i = 1'b0; shift_i = 1'b0;
        if (sh) exp_off = shr ? (exp_off + 79) % 80 : (exp_off + 1) % 80;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_off = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        mode_i = 2'd0;
        #1;
        check("R1 addr", int'(addr_o), 0);
        check("R1 sel", int'(char_sel_o), 0);
        check("R1 vis5", vis(5), 5);
        check("R1 vis31", vis(31), 31);
    endtask

    task automatic t_loads();
        do_reset();
        pulse(1, 0, 7'h45, 0, 1, 0, 0);
        check("R2 disp load", int'(addr_o), 'h45);
        check("R2 sel disp", int'(char_sel_o), 0);
        pulse(0, 1, 7'h2A, 0, 1, 0, 0);
        check("R2 char load keeps bit6", int'(addr_o), 'h6A);
        check("R2 sel char", int'(char_sel_o), 1);
        pulse(1, 0, 7'h10, 1, 1, 0, 0);
        check("R2 load beats step", int'(addr_o), 'h10);
        pulse(1, 1, 7'h22, 0, 1, 0, 0);
        check("R2 disp beats char addr", int'(addr_o), 'h22);
        check("R2 disp beats char sel", int'(char_sel_o), 0);
    endtask

    task automatic t_char_count();
        do_reset();
        mode_i = 2'd1;
        pulse(0, 1, 7'h3F, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R3 carry into bit6", int'(addr_o), 'h40);
        pulse(0, 0, 7'h00, 1, 0, 0, 0);
        check("R3 borrow from bit6", int'(addr_o), 'h3F);
        pulse(1, 0, 7'h67, 0, 1, 0, 0);
        pulse(0, 1, 7'h27, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R3 no line jump in char mode", int'(addr_o), 'h68);
        pulse(1, 0, 7'h40, 0, 1, 0, 0);
        pulse(0, 1, 7'h3F, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R3 7F rolls to 00", int'(addr_o), 'h00);
    endtask

    task automatic t_wide();
        do_reset();
        mode_i = 2'd0;
        pulse(1, 0, 7'h4E, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R4 4E up", int'(addr_o), 'h4F);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R4 4F up", int'(addr_o), 'h00);
        pulse(0, 0, 7'h00, 1, 0, 0, 0);
        check("R4 00 down", int'(addr_o), 'h4F);
        pulse(1, 0, 7'h27, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R4 27 up plain", int'(addr_o), 'h28);
        mode_i = 2'd3;
        pulse(1, 0, 7'h4F, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R4 code3 4F up", int'(addr_o), 'h00);
    endtask

    task automatic t_dual();
        do_reset();
        mode_i = 2'd1;
        pulse(1, 0, 7'h27, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R5 27 up", int'(addr_o), 'h40);
        pulse(0, 0, 7'h00, 1, 0, 0, 0);
        check("R5 40 down", int'(addr_o), 'h27);
        pulse(1, 0, 7'h67, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R5 67 up", int'(addr_o), 'h00);
        pulse(0, 0, 7'h00, 1, 0, 0, 0);
        check("R5 00 down", int'(addr_o), 'h67);
        pulse(1, 0, 7'h10, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R5 mid up", int'(addr_o), 'h11);
    endtask

    task automatic t_narrow();
        do_reset();
        mode_i = 2'd2;
        pulse(1, 0, 7'h27, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R6 27 up", int'(addr_o), 'h00);
        pulse(0, 0, 7'h00, 1, 0, 0, 0);
        check("R6 00 down", int'(addr_o), 'h27);
    endtask

    task automatic t_shift();
        do_reset();
        mode_i = 2'd1;
        pulse(1, 0, 7'h33, 0, 1, 0, 0);
        pulse(0, 0, 7'h00, 0, 1, 1, 1);
        check("R8 right p0", vis(0), 'h27);
        check("R8 right p1", vis(1), 'h00);
        check("R8 right p16", vis(16), 'h67);
        check("R8 right p17", vis(17), 'h40);
        check("R11 shift keeps addr", int'(addr_o), 'h33);
        pulse(0, 0, 7'h00, 0, 1, 1, 0);
        pulse(0, 0, 7'h00, 0, 1, 1, 0);
        check("R7 net left p0", vis(0), 'h01);
        check("R7 net left p15", vis(15), 'h10);
        check("R8 net left p16", vis(16), 'h41);
        pulse(0, 0, 7'h00, 1, 1, 0, 0);
        check("R11 step keeps offset", vis(0), exp_vis(1, exp_off, 0));
        mode_i = 2'd0;
        #1;
        check("R9 wide p31 off1", vis(31), exp_vis(0, exp_off, 31));
        pulse(0, 0, 7'h00, 0, 1, 1, 1);
        pulse(0, 0, 7'h00, 0, 1, 1, 1);
        check("R9 wide right p0", vis(0), 'h4F);
        check("R9 wide right p1", vis(1), 'h00);
        for (int k = 0; k < 80; k++) pulse(0, 0, 7'h00, 0, 1, 1, 0);
        check("R7 full circuit p0", vis(0), exp_vis(0, exp_off, 0));
        mode_i = 2'd2;
        for (int k = 0; k < 45; k++) pulse(0, 0, 7'h00, 0, 1, 1, 0);
        #1;
        for (int p = 0; p < 32; p++) begin
            check($sformatf("R10 narrow p%0d", p), vis(p), exp_vis(2, exp_off, p));
        end
        mode_i = 2'd1;
        #1;
        for (int p = 0; p < 32; p++) begin
            check($sformatf("R8 dual p%0d", p), vis(p), exp_vis(1, exp_off, p));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_loads();
        t_char_count();
        t_wide();
        t_dual();
        t_narrow();
        t_shift();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule